// File: doc/BRIEF.md
# 100 Mb/s 4B/5B Transmit Symbol Encoder

This block takes the nibble-wide transmit side of a media-independent interface and turns it into a serial 4B/5B code stream, one bit per clock, for the physical medium attachment. A strobe, `tx_ce`, is high for one clock in five. On each strobe the block samples the transmit nibble, its enable and its error flag. It then picks a 5-bit code group and loads it into a shifter, which sends the group out over the next five clocks.

Between frames the stream carries idle codes. When a frame begins, the two leading preamble nibbles are replaced by a start-of-stream delimiter pair. Every later nibble is sent as its data code, or as the error code when flagged. When the enable drops, an end-of-stream delimiter pair follows the last nibble and the stream returns to idle. A low `link_status` forces idle and abandons any frame in progress. Scrambling and line coding are handled downstream.

Top module: `fx_tx_encoder`

## Requirements
- R1: While `rst` is high the serial output `pma_bit` is 1, and the first code group after reset is idle.
- R2: While `tx_en` is low and no delimiter or error code is owed, each strobe loads the idle code 11111, whatever the values of `txd` and `tx_er`.
- R3: On the first strobe with `tx_en` high after idle, the code loaded is 11000. On the following strobe the code loaded is always 10001. The nibbles sampled on those two strobes are not sent.
- R4: From the third strobe of a frame on, a nibble with `tx_er` low is sent as its data code. Nibbles 0 to F map to 11110, 01001, 10100, 10101, 01010, 01011, 01110, 01111, 10010, 10011, 10110, 10111, 11010, 11011, 11100, 11101.
- R5: From the third strobe of a frame on, a nibble sampled with `tx_en` and `tx_er` both high is sent as the error code 00100.
- R6: If `tx_er` is high on either of the first two strobes of a frame, both start delimiter codes are still sent and the third code group is 00100. This holds even when `tx_en` has already fallen; in that case the error code is followed by the end delimiter.
- R7: On the first strobe with `tx_en` low after frame data, the code 01101 is loaded. On the next strobe the code is 00111. After that the stream returns to idle.
- R8: Each code group is loaded on the clock edge where `tx_ce` is high. The group appears on `pma_bit` most significant bit first, one bit per clock, over the five clocks that follow.
- R9: On any strobe with `link_status` low, the idle code is loaded and any frame in progress is abandoned. No end delimiter is sent for it.
- R10: A new frame may start on the strobe directly after the one that loaded 00111.
- R11: Each frame carries exactly one 11000/10001 pair and exactly one 01101/00111 pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_ce | input | 1 | One-in-five strobe that marks a code group boundary |
| txd | input | 4 | Transmit nibble |
| tx_en | input | 1 | Frame enable |
| tx_er | input | 1 | Transmit error flag for the current nibble |
| link_status | input | 1 | Link up; low forces idle |
| pma_bit | output | 1 | Serial code bit toward the medium attachment |

## Verification
The hardest situation to reach is an error flagged inside the start delimiter of a very short frame. Here the error code is owed after the enable has already fallen, so the end delimiter has to wait one group. Directed frames of one and two nibbles, each with the error flag on the first or the second nibble, drive this path. Random frames of one to thirty nibbles, with errors sprinkled in at random, then hit it again from the other slots. A link drop in the middle of a frame, followed by back-to-back frames with no idle gap, covers the abort path and the immediate restart.

// File: rtl/fx_enc_pkg.sv
package fx_enc_pkg;

    localparam int CODE_W = 5;
    localparam int NIB_W  = 4;

    typedef logic [CODE_W-1:0] code_t;

    localparam code_t SYM_IDLE = 5'b11111;
    localparam code_t SYM_SSD1 = 5'b11000;
    localparam code_t SYM_SSD2 = 5'b10001;
    localparam code_t SYM_ESD1 = 5'b01101;
    localparam code_t SYM_ESD2 = 5'b00111;
    localparam code_t SYM_ERR  = 5'b00100;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_SSD2,
        SQ_DATA,
        SQ_ESD1,
        SQ_ESD2
    } seq_e;

    typedef struct packed {
        logic             en;
        logic             er;
        logic [NIB_W-1:0] d;
    } mii_nib_t;

    function automatic code_t data_code(input logic [NIB_W-1:0] n);
        code_t c;
        case (n)
            4'h0: c = 5'b11110;
            4'h1: c = 5'b01001;
            4'h2: c = 5'b10100;
            4'h3: c = 5'b10101;
            4'h4: c = 5'b01010;
            4'h5: c = 5'b01011;
            4'h6: c = 5'b01110;
            4'h7: c = 5'b01111;
            4'h8: c = 5'b10010;
            4'h9: c = 5'b10011;
            4'hA: c = 5'b10110;
            4'hB: c = 5'b10111;
            4'hC: c = 5'b11010;
            4'hD: c = 5'b11011;
            4'hE: c = 5'b11100;
            default: c = 5'b11101;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fx_enc_sequencer.sv
module fx_enc_sequencer
    import fx_enc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     strobe,
    input  logic     link_up,
    input  mii_nib_t nib,
    output code_t    sym,
    output seq_e     seq_q
);

    seq_e seq_n;
    logic err_owed_q, err_owed_n;

    // Pick the code group for the current strobe and the state that follows it.
    always_comb begin
        sym        = SYM_IDLE;
        seq_n      = seq_q;
        err_owed_n = err_owed_q;
        if (!link_up) begin
            sym        = SYM_IDLE;
            seq_n      = SQ_IDLE;
            err_owed_n = 1'b0;
        end else begin
            unique case (seq_q)
                SQ_IDLE: begin
                    if (nib.en) begin
                        sym        = SYM_SSD1;
                        seq_n      = SQ_SSD2;
                        err_owed_n = nib.er;
                    end
                end
                SQ_SSD2: begin
                    sym        = SYM_SSD2;
                    seq_n      = SQ_DATA;
                    err_owed_n = err_owed_q | (nib.en & nib.er);
                end
                SQ_DATA: begin
                    if (err_owed_q) begin
                        sym        = SYM_ERR;
                        err_owed_n = 1'b0;
                        seq_n      = nib.en ? SQ_DATA : SQ_ESD1;
                    end else if (nib.en) begin
                        sym = nib.er ? SYM_ERR : data_code(nib.d);
                    end else begin
                        sym   = SYM_ESD1;
                        seq_n = SQ_ESD2;
                    end
                end
                SQ_ESD1: begin
                    sym   = SYM_ESD1;
                    seq_n = SQ_ESD2;
                end
                SQ_ESD2: begin
                    sym   = SYM_ESD2;
                    seq_n = SQ_IDLE;
                end
                default: begin
                    sym   = SYM_IDLE;
                    seq_n = SQ_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seq_q      <= SQ_IDLE;
            err_owed_q <= 1'b0;
        end else if (strobe) begin
            seq_q      <= seq_n;
            err_owed_q <= err_owed_n;
        end
    end

endmodule

// File: rtl/fx_enc_serializer.sv
module fx_enc_serializer #(
    parameter int W         = 5,
    parameter bit MSB_FIRST = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic [W-1:0] sh_q,
    output logic         bit_o
);

    localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

    logic [W-1:0] sh_n;

    generate
        if (MSB_FIRST) begin : g_msb
            assign sh_n  = {sh_q[W-2:0], 1'b1};
            assign bit_o = sh_q[W-1];
        end else begin : g_lsb
            assign sh_n  = {1'b1, sh_q[W-1:1]};
            assign bit_o = sh_q[0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)       sh_q <= ALL_ONES;
        else if (load) sh_q <= word;
        else           sh_q <= sh_n;
    end

endmodule

// File: rtl/fx_tx_encoder.sv
module fx_tx_encoder
    import fx_enc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tx_ce,
    input  logic [NIB_W-1:0] txd,
    input  logic             tx_en,
    input  logic             tx_er,
    input  logic             link_status,
    output logic             pma_bit
);

    mii_nib_t nib;
    code_t    sym_code;
    code_t    shift_q;
    seq_e     seq_q;

    assign nib = '{en: tx_en, er: tx_er, d: txd};

    fx_enc_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .strobe  (tx_ce),
        .link_up (link_status),
        .nib     (nib),
        .sym     (sym_code),
        .seq_q   (seq_q)
    );

    fx_enc_serializer #(
        .W         (CODE_W),
        .MSB_FIRST (1'b1)
    ) u_ser (
        .clk   (clk),
        .rst   (rst),
        .load  (tx_ce),
        .word  (sym_code),
        .sh_q  (shift_q),
        .bit_o (pma_bit)
    );

endmodule

// File: rtl/fx_tx_encoder_chk.sv
module fx_tx_encoder_chk
    import fx_enc_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  tx_ce,
    input logic  tx_en,
    input logic  tx_er,
    input logic  link_status,
    input code_t ld_code,
    input code_t shift_q,
    input logic  pma_bit
);

    code_t last_q;

    always_ff @(posedge clk) begin
        if (rst)        last_q <= SYM_IDLE;
        else if (tx_ce) last_q <= ld_code;
    end

    // R1
    a_r1_reset_high: assert property (@(posedge clk) rst |=> pma_bit);

    // R8
    a_r8_load_at_strobe: assert property (@(posedge clk) disable iff (rst)
        tx_ce |=> shift_q == $past(ld_code));

    // R8
    a_r8_msb_shift: assert property (@(posedge clk) disable iff (rst)
        !tx_ce |=> shift_q == {$past(shift_q[3:0]), 1'b1});

    // R2
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (tx_ce && link_status && !tx_en && (last_q == SYM_IDLE || last_q == SYM_ESD2))
        |-> ld_code == SYM_IDLE);

    // R3
    a_r3_k_after_j: assert property (@(posedge clk) disable iff (rst)
        (tx_ce && link_status && last_q == SYM_SSD1) |-> ld_code == SYM_SSD2);

    // R7
    a_r7_r_after_t: assert property (@(posedge clk) disable iff (rst)
        (tx_ce && link_status && last_q == SYM_ESD1) |-> ld_code == SYM_ESD2);

    // R5
    a_r5_err_after_k: assert property (@(posedge clk) disable iff (rst)
        (tx_ce && link_status && last_q == SYM_SSD2 && tx_en && tx_er) |-> ld_code == SYM_ERR);

    // R9
    a_r9_link_down_idle: assert property (@(posedge clk) disable iff (rst)
        (tx_ce && !link_status) |-> ld_code == SYM_IDLE);

endmodule

bind fx_tx_encoder fx_tx_encoder_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_ce       (tx_ce),
    .tx_en       (tx_en),
    .tx_er       (tx_er),
    .link_status (link_status),
    .ld_code     (sym_code),
    .shift_q     (shift_q),
    .pma_bit     (pma_bit)
);

// File: tb/fx_tx_encoder_tb.sv
module fx_tx_encoder_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tx_ce = 1'b0;
    logic [3:0] txd = 4'h0;
    logic       tx_en = 1'b0;
    logic       tx_er = 1'b0;
    logic       link_status = 1'b1;
    logic       pma_bit;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    localparam logic [4:0] E_I = 5'b11111, E_J = 5'b11000, E_K = 5'b10001,
                           E_T = 5'b01101, E_R = 5'b00111, E_H = 5'b00100;

    logic [3:0] fnib [64];
    bit         fer  [64];
    int         flen;

    always #10 clk = ~clk;

    fx_tx_encoder u_dut (
        .clk(clk), .rst(rst), .tx_ce(tx_ce), .txd(txd), .tx_en(tx_en),
        .tx_er(tx_er), .link_status(link_status), .pma_bit(pma_bit)
    );

    function automatic logic [4:0] ref_code(input logic [3:0] n);
        logic [4:0] t [16] = '{5'b11110, 5'b01001, 5'b10100, 5'b10101,
                               5'b01010, 5'b01011, 5'b01110, 5'b01111,
                               5'b10010, 5'b10011, 5'b10110, 5'b10111,
                               5'b11010, 5'b11011, 5'b11100, 5'b11101};
        return t[n];
    endfunction

    task automatic check(input bit ok, input string req, input logic [4:0] act, input logic [4:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // Called at a falling edge; returns the code group sent for this strobe.
    task automatic slot(input bit en, input bit er, input logic [3:0] d, input bit lk,
                        output logic [4:0] got);
        tx_ce = 1'b1; tx_en = en; tx_er = er; txd = d; link_status = lk;
        @(posedge clk); @(negedge clk);
        tx_ce = 1'b0;
        got[4] = pma_bit;
        for (int b = 3; b >= 0; b--) begin
            @(posedge clk); @(negedge clk);
            got[b] = pma_bit;
        end
    endtask

    task automatic run_frame(input int gap, input string tag);
        bit pend;
        int dend, nj, nt;
        logic [4:0] got, exp;
        pend = fer[0] | (flen > 1 && fer[1]);
        dend = (flen > 2) ? flen : 2;
        if (pend && flen <= 2) dend++;
        nj = 0; nt = 0;
        for (int s = 0; s < dend + 2 + gap; s++) begin
            bit en = (s < flen);
            slot(en, en ? fer[s] : 1'($urandom), en ? fnib[s] : 4'($urandom), 1'b1, got);
            if (s == 0)                exp = E_J;
            else if (s == 1)           exp = E_K;
            else if (s == 2 && pend)   exp = E_H;
            else if (s < dend)         exp = fer[s] ? E_H : ref_code(fnib[s]);
            else if (s == dend)        exp = E_T;
            else if (s == dend + 1)    exp = E_R;
            else                       exp = E_I;
            if (s < 2)                 check(got == exp, {tag, " R3"}, got, exp);
            else if (s == 2 && pend)   check(got == exp, {tag, " R6"}, got, exp);
            else if (s < dend)         check(got == exp, fer[s] ? {tag, " R5"} : {tag, " R4"}, got, exp);
            else if (s <= dend + 1)    check(got == exp, {tag, " R7"}, got, exp);
            else                       check(got == exp, {tag, " R2"}, got, exp);
            if (got == E_J) nj++;
            if (got == E_T) nt++;
        end
        check(nj == 1, {tag, " R11 start count"}, 5'(nj), 5'd1);
        check(nt == 1, {tag, " R11 end count"}, 5'(nt), 5'd1);
    endtask

    task automatic set_frame(input int len);
        flen = len;
        for (int i = 0; i < 64; i++) begin
            fnib[i] = (i < 2) ? 4'h5 : 4'($urandom);
            fer[i]  = 1'b0;
        end
    endtask

    initial begin
        logic [4:0] got;
        void'($urandom(32'd20517));
        repeat (3) @(negedge clk);
        check(pma_bit == 1'b1, "R1 output high in reset", {4'b0, pma_bit}, 5'd1);
        rst = 1'b0;

        // R1 / R2: idle after reset, error flag without enable ignored
        slot(1'b0, 1'b0, 4'h3, 1'b1, got);
        check(got == E_I, "R1 first group idle", got, E_I);
        slot(1'b0, 1'b1, 4'h0, 1'b1, got);
        check(got == E_I, "R2 tx_er without tx_en", got, E_I);

        // R4: every nibble value in order
        set_frame(18);
        for (int i = 2; i < 18; i++) fnib[i] = 4'(i - 2);
        run_frame(2, "all-nibbles");

        // R5: error in mid frame
        set_frame(12);
        fer[7] = 1'b1;
        run_frame(1, "mid-error");

        // R6: short frames with errors in the start delimiter
        set_frame(1); fer[0] = 1'b1; run_frame(1, "err-only");
        set_frame(2); fer[1] = 1'b1; run_frame(1, "five-then-err");
        set_frame(6); fer[0] = 1'b1; run_frame(1, "err-first-long");
        set_frame(1); run_frame(1, "one-nibble");
        set_frame(2); run_frame(0, "two-nibble");

        // R10: back-to-back frames with no idle gap
        set_frame(5); run_frame(0, "b2b-a");
        set_frame(4); run_frame(1, "b2b-b R10");

        // R9: link drop in the middle of a frame
        set_frame(10);
        for (int s = 0; s < 4; s++) slot(1'b1, 1'b0, fnib[s], 1'b1, got);
        slot(1'b1, 1'b0, 4'h9, 1'b0, got);
        check(got == E_I, "R9 link drop idle", got, E_I);
        slot(1'b1, 1'b1, 4'h2, 1'b0, got);
        check(got == E_I, "R9 link low ignores frame", got, E_I);
        slot(1'b0, 1'b0, 4'h0, 1'b1, got);
        check(got == E_I, "R9 no end delimiter after abort", got, E_I);
        slot(1'b0, 1'b0, 4'h0, 1'b1, got);
        check(got == E_I, "R9 stays idle", got, E_I);
        set_frame(7); run_frame(1, "after-link R9");

        // Random frames
        for (int f = 0; f < 40; f++) begin
            set_frame(1 + int'($urandom % 30));
            for (int i = 0; i < flen; i++) fer[i] = (($urandom % 8) == 0);
            run_frame(int'($urandom % 4), "random");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule